// File: doc/BRIEF.md
# Registered Eight-Function Bit-Slice ALU

This block is a parameterised-width ALU. Every one of its eight operations is computed in parallel in every cycle, and a 3-bit operation code picks which result is loaded into the output register. The addition and subtraction path is a ripple chain of per-bit full-adder slices, built with a generate loop. Subtraction reuses that chain: the second operand is inverted and the chain starts with a carry-in of one, which adds its two's complement. The remaining operations pass an operand through unchanged or shift it by one bit.

The result, the carry flag and the overflow flag are registered on the rising clock edge. Each therefore appears one cycle after the operands and the code are presented. An active-low asynchronous reset clears all three registers. Every code defines every output, so no storage is inferred outside the registers.

Top module: `slice_alu`

## Requirements
- R1: While rst_ni is low, res_o, carry_o and ovf_o are all 0.
- R2: Code 3'b000 loads operand a; code 3'b001 loads operand b. Both clear carry_o and ovf_o.
- R3: Code 3'b010 loads (a + b) mod 2^W. carry_o is the carry out of bit W-1. ovf_o is 1 when the signed sum of two same-signed operands changes sign.
- R4: Code 3'b011 loads (a - b) mod 2^W, computed as a + ~b + 1. carry_o is the carry out of bit W-1 of that addition, so it is 1 when a >= b unsigned. ovf_o flags signed overflow of the subtraction.
- R5: Code 3'b100 loads a shifted left by one bit with 0 in bit 0; code 3'b101 does the same to b. Both clear carry_o and ovf_o.
- R6: Code 3'b110 loads a shifted right logically by one bit with 0 in bit W-1; code 3'b111 does the same to b. Both clear carry_o and ovf_o.
- R7: Outputs change only on a rising clock edge. They reflect the inputs sampled at the previous edge.
- R8: The operand width W is a parameter with a default of 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | W | Operand a |
| b_i | input | W | Operand b |
| op_i | input | 3 | Operation code |
| res_o | output | W | Registered result |
| carry_o | output | 1 | Registered carry out |
| ovf_o | output | 1 | Registered signed overflow |

## Verification
On every cycle, the assertions check the following:
- The flags stay clear after any pass or shift code.
- The overflow flag is never set unless the sampled operands gave a sign pattern that allows overflow.
- The registered result of a pass or shift code matches the operand that was sampled.
- The outputs are cleared during reset.

The arithmetic values need the bench's scenarios. These are the exact sums and differences, the carry at the wrap-around boundaries, and signed overflow at the most-positive and most-negative operands.

// File: rtl/slice_alu_pkg.sv
package slice_alu_pkg;
  typedef enum logic [2:0] {
    OP_PASS_A = 3'b000,
    OP_PASS_B = 3'b001,
    OP_ADD    = 3'b010,
    OP_SUB    = 3'b011,
    OP_SHL_A  = 3'b100,
    OP_SHL_B  = 3'b101,
    OP_SHR_A  = 3'b110,
    OP_SHR_B  = 3'b111
  } alu_op_e;
endpackage

// File: rtl/slice_fa.sv
module slice_fa (
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);
  assign s_o = x_i ^ y_i ^ c_i;
  assign c_o = (x_i & y_i) | (x_i & c_i) | (y_i & c_i);
endmodule

// File: rtl/slice_ripple.sv
module slice_ripple #(
  parameter int W = 8
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);
  logic [W:0] c;
  assign c[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_slice
    slice_fa i_fa (
      .x_i(x_i[i]), .y_i(y_i[i]), .c_i(c[i]),
      .s_o(sum_o[i]), .c_o(c[i+1])
    );
  end

  assign cout_o = c[W];
  assign ovf_o  = c[W] ^ c[W-1];
endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import slice_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [2:0]   op_i,
  output logic [W-1:0] res_o,
  output logic         carry_o,
  output logic         ovf_o
);
  localparam int MSB = W - 1;

  alu_op_e     op;
  logic        is_sub;
  logic [W-1:0] y_sel, sum;
  logic        cout, vout;
  logic [W-1:0] res_d;
  logic        carry_d, ovf_d;

  assign op     = alu_op_e'(op_i);
  assign is_sub = (op == OP_SUB);
  // subtract: a + ~b + 1 on the same chain
  assign y_sel  = is_sub ? ~b_i : b_i;

  slice_ripple #(.W(W)) i_chain (
    .x_i(a_i), .y_i(y_sel), .cin_i(is_sub),
    .sum_o(sum), .cout_o(cout), .ovf_o(vout)
  );

  always_comb begin
    res_d   = '0;
    carry_d = 1'b0;
    ovf_d   = 1'b0;
    unique case (op)
      OP_PASS_A: res_d = a_i;
      OP_PASS_B: res_d = b_i;
      OP_ADD, OP_SUB: begin
        res_d   = sum;
        carry_d = cout;
        ovf_d   = vout;
      end
      OP_SHL_A: res_d = {a_i[MSB-1:0], 1'b0};
      OP_SHL_B: res_d = {b_i[MSB-1:0], 1'b0};
      OP_SHR_A: res_d = {1'b0, a_i[MSB:1]};
      OP_SHR_B: res_d = {1'b0, b_i[MSB:1]};
      default:  res_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o   <= '0;
      carry_o <= 1'b0;
      ovf_o   <= 1'b0;
    end else begin
      res_o   <= res_d;
      carry_o <= carry_d;
      ovf_o   <= ovf_d;
    end
  end

  // R1: reset clears outputs
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      a_rst_clear_r1: assert (res_o == '0 && !carry_o && !ovf_o);
    end
  end

  // R2/R5/R6: non-arithmetic codes clear flags
  p_flags_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[2] || op_i[2:1] == 2'b00) |=> (!carry_o && !ovf_o));

  // R2: pass A lands in result
  p_pass_a_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b000) |=> (res_o == $past(a_i)));

  // R6: right shift of A clears MSB and holds shifted bits
  p_shr_a_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b110) |=> (res_o == ($past(a_i) >> 1)));

  // R3: add overflow only with like-signed operands
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b010 && (a_i[MSB] != b_i[MSB])) |=> !ovf_o);

  // R4: subtract overflow only with unlike-signed operands
  p_no_overflow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'b011 && (a_i[MSB] == b_i[MSB])) |=> !ovf_o);
endmodule

// File: tb/test_slice_alu.sv
module test_slice_alu;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [2:0]   op_i = '0;
  logic [W-1:0] res_o;
  logic         carry_o, ovf_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  slice_alu #(.W(W)) i_slice_alu (
    .clk_i, .rst_ni, .a_i, .b_i, .op_i, .res_o, .carry_o, .ovf_o
  );

  task automatic chk(string req, logic [W+1:0] act, logic [W+1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // apply on negedge, sample after next posedge (at following negedge)
  task automatic run(string req, logic [2:0] op, logic [W-1:0] a, logic [W-1:0] b,
                     logic [W-1:0] er, logic ec, logic ev);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b;
    @(negedge clk_i);
    chk(req, {res_o, carry_o, ovf_o}, {er, ec, ev});
  endtask

  task automatic t_reset();
    chk("R1", {res_o, carry_o, ovf_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  task automatic t_pass();
    run("R2", 3'b000, 8'hA5, 8'h3C, 8'hA5, 0, 0);
    run("R2", 3'b001, 8'hA5, 8'h3C, 8'h3C, 0, 0);
  endtask

  task automatic t_add();
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a = W'(i * 37 + 11), b = W'(i * 91 + 5);
      logic [W:0] s = {1'b0, a} + {1'b0, b};
      logic v = (a[W-1] == b[W-1]) && (s[W-1] != a[W-1]);
      run("R3", 3'b010, a, b, s[W-1:0], s[W], v);
    end
    run("R3", 3'b010, 8'h7F, 8'h01, 8'h80, 0, 1);
    run("R3", 3'b010, 8'hFF, 8'h01, 8'h00, 1, 0);
    run("R3", 3'b010, 8'h80, 8'h80, 8'h00, 1, 1);
  endtask

  task automatic t_sub();
    for (int i = 0; i < 20; i++) begin
      logic [W-1:0] a = W'(i * 53 + 3), b = W'(i * 29 + 17);
      logic [W-1:0] d = a - b;
      logic c = (a >= b);
      logic v = (a[W-1] != b[W-1]) && (d[W-1] != a[W-1]);
      run("R4", 3'b011, a, b, d, c, v);
    end
    run("R4", 3'b011, 8'h80, 8'h01, 8'h7F, 1, 1);
    run("R4", 3'b011, 8'h05, 8'h05, 8'h00, 1, 0);
    run("R4", 3'b011, 8'h00, 8'h01, 8'hFF, 0, 0);
  endtask

  task automatic t_shift();
    run("R5", 3'b100, 8'hC3, 8'h81, 8'h86, 0, 0);
    run("R5", 3'b101, 8'hC3, 8'h81, 8'h02, 0, 0);
    run("R6", 3'b110, 8'hC3, 8'h81, 8'h61, 0, 0);
    run("R6", 3'b111, 8'hC3, 8'h81, 8'h40, 0, 0);
  endtask

  task automatic t_timing();
    // R7: change inputs mid-cycle, outputs hold until the edge
    @(negedge clk_i);
    op_i = 3'b000; a_i = 8'h11;
    @(negedge clk_i);
    a_i = 8'h22;
    #1;
    chk("R7", {res_o, carry_o, ovf_o}, {8'h11, 2'b00});
    @(negedge clk_i);
    chk("R7", {res_o, carry_o, ovf_o}, {8'h22, 2'b00});
    // R8: default width is 8 bits, carry out from bit 7
    run("R8", 3'b010, 8'h80, 8'h80, 8'h00, 1, 1);
    // R1: async reset clears mid-cycle
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1", {res_o, carry_o, ovf_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  initial begin
    #30000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk_i);
    t_reset();
    t_pass();
    t_add();
    t_sub();
    t_shift();
    t_timing();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule